// File: doc/BRIEF.md
# Register Access Command Channel

This block is a single access channel that lets a processor reach the registers of a remote slave, one access at a time. Software writes a 32-bit command word that holds a direction flag, a halfword address and write data. The channel latches the command and raises a request towards a downstream transport. When the transport grants the request, a write is finished from the channel's point of view and the channel goes back to idle. A read instead waits for the transport to return data, and then holds that data until software acknowledges it.

Software learns about progress only from a status word. It polls that word until the state field reads idle, writes a command, and for a read polls again until the state field reads wait-for-clear. It then takes the data and writes 1 to the valid-clear input. The status word also carries a sync-idle bit, which is high when no transport transaction is outstanding, an init-done flag that software sets, and a sticky error bit. The error bit records any command that was written while the channel was busy.

Top module: `regacc_channel`

## Requirements
- R1: After reset the state field is idle, sync-idle is 1, the error bit and the init-done flag are 0, the read data is 0 and no transport request is raised. The status word packs the read data in bits 15:0, the state in bits 17:16, sync-idle in bit 18, init-done in bit 19 and the error bit in bit 20. The state codes are 0 idle, 1 request, 2 wait-for-data and 3 wait-for-clear.
- R2: A command accepted in idle moves the state to request on the next cycle. The transport then sees the direction from command bit 31 (1 = write), the halfword address from bits 30:16 and the write data from bits 15:0.
- R3: In the request state a write returns to idle in the cycle after the grant.
- R4: In the request state a read moves to wait-for-data in the cycle after the grant. The done strobe then captures the transport's read data and moves the state to wait-for-clear.
- R5: A valid-clear write with its data bit at 1 returns wait-for-clear to idle. A valid-clear write with its data bit at 0, or one made in any other state, changes nothing.
- R6: The read data in the status word stays unchanged from entry into wait-for-clear until the clear, even if the transport signals change or done pulses again.
- R7: A command written while the state is not idle is dropped: the latched command and the state do not change. It also sets the error bit, which stays set until reset.
- R8: Sync-idle falls in the cycle after a grant and rises again in the cycle after the matching done.
- R9: The request is withheld while a transaction is still outstanding. Once raised, it stays raised until it is granted.
- R10: An init write loads its data bit into the init-done flag of the status word on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_we | input | 1 | Command word write strobe |
| cmd_word | input | 32 | Command word: direction, halfword address, write data |
| vclr_we | input | 1 | Valid-clear write strobe |
| vclr_bit | input | 1 | Valid-clear data bit |
| init_we | input | 1 | Init-done flag write strobe |
| init_val | input | 1 | Init-done flag value |
| xfer_req | output | 1 | Request to the transport |
| xfer_write | output | 1 | Direction of the pending request |
| xfer_addr | output | 15 | Halfword address of the pending request |
| xfer_wdata | output | 16 | Write data of the pending request |
| xfer_grant | input | 1 | Transport accepts the request |
| xfer_done | input | 1 | Transport finished the accepted transaction |
| xfer_rdata | input | 16 | Read data from the transport, valid with done |
| stat_word | output | 21 | Status word: read data, state, sync-idle, init-done, error |

## Verification
The assertions assume that the transport keeps to its handshake. A grant arrives only in a cycle where the request is high, and a done arrives only for a transaction that was granted earlier. The bench drives grant only after it has seen the request and pulses done once per granted transaction. Its only stray done pulse falls in wait-for-clear, where nothing is outstanding, and that case is used to show that the held read data does not move. Misuse by software is different: a command written while busy, or a valid-clear outside wait-for-clear, is legal input. The bench exercises both on purpose and checks the result at the status word.

// File: rtl/regacc_channel.sv
module regacc_channel #(
  parameter int AW = 15,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_we,
  input  logic [AW+DW:0] cmd_word,
  input  logic          vclr_we,
  input  logic          vclr_bit,
  input  logic          init_we,
  input  logic          init_val,
  output logic          xfer_req,
  output logic          xfer_write,
  output logic [AW-1:0] xfer_addr,
  output logic [DW-1:0] xfer_wdata,
  input  logic          xfer_grant,
  input  logic          xfer_done,
  input  logic [DW-1:0] xfer_rdata,
  output logic [DW+4:0] stat_word
);
  localparam int CW = AW + DW + 1;

  typedef enum logic [1:0] {S_IDLE = 2'd0, S_REQ = 2'd1, S_WDATA = 2'd2, S_WCLR = 2'd3} st_t;

  st_t           st;
  logic [CW-1:0] cmd_q;
  logic [DW-1:0] rdata_q;
  logic          pend, err_q, init_q;

  wire accept = xfer_req && xfer_grant;

  assign xfer_req   = (st == S_REQ) && !pend;
  assign xfer_write = cmd_q[CW-1];
  assign xfer_addr  = cmd_q[CW-2:DW];
  assign xfer_wdata = cmd_q[DW-1:0];
  assign stat_word  = {err_q, init_q, !pend, st, rdata_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cmd_q   <= '0;
      rdata_q <= '0;
      pend    <= 1'b0;
      err_q   <= 1'b0;
      init_q  <= 1'b0;
    end else begin
      if (init_we) init_q <= init_val;
      if (cmd_we && st != S_IDLE) err_q <= 1'b1;
      if (accept) pend <= 1'b1;
      else if (xfer_done) pend <= 1'b0;
      case (st)
        S_IDLE:  if (cmd_we) begin cmd_q <= cmd_word; st <= S_REQ; end
        S_REQ:   if (accept) st <= cmd_q[CW-1] ? S_IDLE : S_WDATA;
        S_WDATA: if (xfer_done) begin rdata_q <= xfer_rdata; st <= S_WCLR; end
        S_WCLR:  if (vclr_we && vclr_bit) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_WRITE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && xfer_grant && xfer_write) |=> (stat_word[DW+1:DW] == 2'd0)); // R3
  AST_READ_TO_WDATA: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && xfer_grant && !xfer_write) |=> (stat_word[DW+1:DW] == 2'd2)); // R4
  AST_CLEAR_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_word[DW+1:DW] == 2'd3 && vclr_we && vclr_bit) |=> (stat_word[DW+1:DW] == 2'd0)); // R5
  AST_RDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_word[DW+1:DW] == 2'd3 && $past(stat_word[DW+1:DW]) == 2'd3) |-> $stable(stat_word[DW-1:0])); // R6
  AST_BUSY_CMD_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && stat_word[DW+1:DW] != 2'd0) |=> (stat_word[DW+4] && $stable(xfer_addr) && $stable(xfer_wdata))); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    stat_word[DW+4] |=> stat_word[DW+4]); // R7
  AST_GRANT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && xfer_grant) |=> !stat_word[DW+2]); // R8
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && !xfer_grant) |=> xfer_req); // R9
  AST_REQ_WHEN_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req |-> stat_word[DW+2]); // R9
endmodule

// File: tb/tb_regacc_channel.sv
module tb_regacc_channel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_we = 1'b0, vclr_we = 1'b0, vclr_bit = 1'b0, init_we = 1'b0, init_val = 1'b0;
  logic [31:0] cmd_word = '0;
  logic        xfer_req, xfer_write, xfer_grant = 1'b0, xfer_done = 1'b0;
  logic [14:0] xfer_addr;
  logic [15:0] xfer_wdata, xfer_rdata = '0;
  logic [20:0] stat_word;
  int total = 0, fails = 0;
  bit ended = 0;

  always #5 clk = ~clk;

  regacc_channel dut (.*);

  localparam logic [47:0] VEC [6] = '{
    {1'b1, 15'h0123, 16'hA55A, 16'h0000},
    {1'b0, 15'h0123, 16'h0000, 16'h5AA5},
    {1'b1, 15'h7FFF, 16'hFFFF, 16'h0000},
    {1'b0, 15'h0000, 16'h0000, 16'h0001},
    {1'b0, 15'h4000, 16'h1234, 16'hFFFF},
    {1'b1, 15'h0001, 16'h0000, 16'hBEEF}
  };

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] fsm(); return stat_word[17:16]; endfunction

  task automatic send(input logic [31:0] w);
    cmd_word = w; cmd_we = 1'b1; tick(); cmd_we = 1'b0;
  endtask

  task automatic clr(input logic b);
    vclr_bit = b; vclr_we = 1'b1; tick(); vclr_we = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!ended) begin
      total++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
    end
  end

  initial begin
    #12; tick();
    chk("R1 state", fsm(), 2'd0);
    chk("R1 word", stat_word, 21'h040000);
    chk("R1 req", xfer_req, 1'b0);
    rst_n = 1'b1; tick();

    for (int i = 0; i < 6; i++) begin
      logic [47:0] v = VEC[i];
      send(v[47:16]);
      chk("R2 state req", fsm(), 2'd1);
      chk("R9 req raised", xfer_req, 1'b1);
      chk("R2 dir", xfer_write, v[47]);
      chk("R2 addr", xfer_addr, v[46:32]);
      chk("R2 wdata", xfer_wdata, v[31:16]);
      tick();
      chk("R9 req held", xfer_req, 1'b1);
      xfer_grant = 1'b1; tick(); xfer_grant = 1'b0;
      chk("R8 busy", stat_word[18], 1'b0);
      chk(v[47] ? "R3 write idle" : "R4 wait data", fsm(), v[47] ? 2'd0 : 2'd2);
      xfer_rdata = v[15:0]; xfer_done = 1'b1; tick(); xfer_done = 1'b0;
      chk("R8 idle again", stat_word[18], 1'b1);
      if (!v[47]) begin
        chk("R4 wait clear", fsm(), 2'd3);
        chk("R4 rdata", stat_word[15:0], v[15:0]);
        xfer_rdata = ~v[15:0]; xfer_done = 1'b1; tick(); xfer_done = 1'b0;
        tick();
        chk("R6 rdata held", stat_word[15:0], v[15:0]);
        clr(1'b0);
        chk("R5 clear zero ignored", fsm(), 2'd3);
        clr(1'b1);
        chk("R5 clear", fsm(), 2'd0);
        chk("R6 rdata after clear", stat_word[15:0], v[15:0]);
      end else begin
        chk("R3 stays idle", fsm(), 2'd0);
      end
    end

    chk("R7 no error yet", stat_word[20], 1'b0);
    clr(1'b1);
    chk("R5 clear in idle ignored", fsm(), 2'd0);

    send(32'h8055_1111);
    send(32'h0066_2222);
    chk("R7 error set", stat_word[20], 1'b1);
    chk("R7 addr kept", xfer_addr, 15'h0055);
    chk("R7 data kept", xfer_wdata, 16'h1111);
    chk("R7 state kept", fsm(), 2'd1);
    xfer_grant = 1'b1; tick(); xfer_grant = 1'b0;
    send(32'h0077_0000);
    chk("R9 state req", fsm(), 2'd1);
    chk("R9 withheld", xfer_req, 1'b0);
    xfer_done = 1'b1; tick(); xfer_done = 1'b0;
    chk("R9 released", xfer_req, 1'b1);
    chk("R2 new addr", xfer_addr, 15'h0077);
    xfer_grant = 1'b1; tick(); xfer_grant = 1'b0;
    xfer_rdata = 16'hC3C3; xfer_done = 1'b1; tick(); xfer_done = 1'b0;
    chk("R4 rdata late", stat_word[15:0], 16'hC3C3);
    clr(1'b1);
    chk("R7 error sticky", stat_word[20], 1'b1);

    init_val = 1'b1; init_we = 1'b1; tick(); init_we = 1'b0;
    chk("R10 init set", stat_word[19], 1'b1);
    init_val = 1'b0; tick();
    chk("R10 no write no change", stat_word[19], 1'b1);
    init_we = 1'b1; tick(); init_we = 1'b0;
    chk("R10 init cleared", stat_word[19], 1'b0);

    ended = 1;
    summary();
  end
endmodule